// File: doc/BRIEF.md
# Vertical Beam Counter with Line Interrupt

This block tracks the vertical scan position of a television-style video output and raises an interrupt request when the scan reaches a line chosen by software. It has a small register bank on a simple synchronous bus that accepts 16-bit and 32-bit accesses. The bank holds a display control word, two framebuffer base addresses, the beam position word and an interrupt control word. A one-cycle `line_step` pulse from the horizontal timing logic moves the counter one line forward.

The line limit for a frame depends on two things in display control. The first is the video standard: 50 Hz-style or 60 Hz-style. The second is whether the output is interlaced. In non-interlaced mode a frame has a half line. The block models this with a field bit, so consecutive fields alternate between the shorter and the longer whole-line count. When the counter passes the limit it restarts at line 1. A match with the trigger line sets a flag that stays set until software writes it clear. The interrupt output follows that flag, gated by an enable bit.

Top module: `vbeam_ctl`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0 (display control reads only the fuse bit in bit 0), the counter is line 0 and `irq` is low.
- R2: Display control bits 9:8 select the standard: value 1 is 50 Hz-style and values 0, 2 and 3 are 60 Hz-style. Bit 2 = 1 selects non-interlaced output and bit 2 = 0 selects interlaced output.
- R3: In interlaced mode the line limit is `NTSC_LINES` or `PAL_LINES`. In non-interlaced mode the limit is half of that value, rounded down, plus the field bit. The field bit toggles on every wrap, so the limit alternates between the shorter and the longer count.
- R4: On a step, the current line (beam position bits 26:16) is incremented. If the result is greater than or equal to the limit, the line becomes 1. All other beam position bits keep their values.
- R5: Without a step and without a bus write to beam position, the beam position register does not change.
- R6: If the incremented line equals the trigger line (interrupt word bits 26:16), bit 31 of the interrupt word is set and stays set. `irq` is high exactly when bit 31 and bit 28 (enable) are both 1.
- R7: Writing the whole interrupt word at 0x30, or its high half at 0x30, replaces bit 31. Writing 0 there drops `irq`. Writing the low half at 0x32 leaves bit 31 as it is.
- R8: Word accesses use offsets 0x00 (display control), 0x1C and 0x24 (framebuffers), 0x2C (beam position) and 0x30 (interrupt). For halfword accesses, the high half of each of the last four is at its word offset and the low half is at offset+2. Display control is a single halfword at 0x02. A halfword write merges into its own half only. Halfword reads return data in bits 15:0.
- R9: Framebuffer bases keep only their low 24 bits, and bits 31:24 read as 0.
- R10: Bit 0 of a display control read always comes from the `fuse_bit` input.
- R11: Any write to display control resets the field bit to its first (shorter) field. The counter value is not changed.
- R12: A read at an unmapped offset returns 0, and a write to an unmapped offset changes nothing.
- R13: A counter that software has loaded at or above the limit (2047 included) wraps to 1 on the next step. A trigger line equal to the limit still matches before the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current access |
| bus_word | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | 7 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data (halfword writes use bits 15:0) |
| bus_rdata | output | 32 | Combinational read data |
| fuse_bit | input | 1 | Value returned in bit 0 of display control reads |
| line_step | input | 1 | One-cycle pulse that advances the beam by one line |
| irq | output | 1 | Line interrupt request |

## Verification
The bench builds the block with `NTSC_LINES` = 11 and `PAL_LINES` = 15. With these values, non-interlaced fields are 5/6 and 7/8 lines long. All four format codes combined with both interlace settings can then run several full frames. The bench sweeps every trigger line from 0 to one past the largest limit, with the enable bit on or off. It compares the beam word, the interrupt word and `irq` against an arithmetic model after every step. The small limits also put the out-of-range counter values and the trigger-equals-limit case only a few steps away.

// File: rtl/vbeam_pkg.sv
package vbeam_pkg;

    localparam int ADDR_W   = 7;
    localparam int POS_LSB  = 16;
    localparam int FLAG_BIT = 31;
    localparam int ENA_BIT  = 28;
    localparam int NIN_BIT  = 2;
    localparam int FMT_LSB  = 8;
    localparam int FB_COUNT = 2;

    typedef enum logic [ADDR_W-1:0] {
        OFS_CTRL_W = 7'h00,
        OFS_CTRL_H = 7'h02,
        OFS_FBT_HI = 7'h1C,
        OFS_FBT_LO = 7'h1E,
        OFS_FBB_HI = 7'h24,
        OFS_FBB_LO = 7'h26,
        OFS_POS_HI = 7'h2C,
        OFS_POS_LO = 7'h2E,
        OFS_IRQ_HI = 7'h30,
        OFS_IRQ_LO = 7'h32
    } reg_ofs_e;

    typedef enum logic [1:0] {
        FMT_SIXTY   = 2'd0,
        FMT_FIFTY   = 2'd1,
        FMT_SIXTY_M = 2'd2,
        FMT_OTHER   = 2'd3
    } fmt_e;

    typedef struct packed {
        logic interlaced;
        logic fifty_hz;
    } timing_mode_t;

    typedef struct packed {
        logic              we;
        logic              word;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       wdata;
    } bus_req_t;

    function automatic timing_mode_t decode_mode(logic [15:0] ctrl);
        timing_mode_t m;
        m.interlaced = ~ctrl[NIN_BIT];
        m.fifty_hz   = (fmt_e'(ctrl[FMT_LSB +: 2]) == FMT_FIFTY);
        return m;
    endfunction

    function automatic logic [ADDR_W-1:0] fb_hi_ofs(int idx);
        return (idx == 0) ? OFS_FBT_HI : OFS_FBB_HI;
    endfunction

    // True when the request writes any part of the register whose high
    // half (and word form) lives at hi_ofs.
    function automatic logic hits_reg(bus_req_t req, logic [ADDR_W-1:0] hi_ofs);
        logic lo_hit;
        lo_hit = (req.addr == hi_ofs + 7'd2);
        return req.we && (req.addr == hi_ofs || (!req.word && lo_hit));
    endfunction

    function automatic logic [31:0] merge_half(logic [31:0] old,
                                               bus_req_t req,
                                               logic [ADDR_W-1:0] hi_ofs);
        if (req.word)
            return req.wdata;
        else if (req.addr == hi_ofs)
            return {req.wdata[15:0], old[15:0]};
        else
            return {old[31:16], req.wdata[15:0]};
    endfunction

endpackage

// File: rtl/vbeam_limit.sv
module vbeam_limit
    import vbeam_pkg::*;
#(
    parameter int LINE_W     = 11,
    parameter int NTSC_LINES = 525,
    parameter int PAL_LINES  = 625
) (
    input  timing_mode_t      mode,
    input  logic              field,
    output logic [LINE_W:0]   limit
);
    localparam logic [LINE_W:0] SIXTY_FULL = (LINE_W+1)'(NTSC_LINES);
    localparam logic [LINE_W:0] FIFTY_FULL = (LINE_W+1)'(PAL_LINES);
    localparam logic [LINE_W:0] SIXTY_HALF = SIXTY_FULL >> 1;
    localparam logic [LINE_W:0] FIFTY_HALF = FIFTY_FULL >> 1;

    logic [LINE_W:0] full_lim;
    logic [LINE_W:0] half_lim;

    always_comb begin
        full_lim = mode.fifty_hz ? FIFTY_FULL : SIXTY_FULL;
        half_lim = (mode.fifty_hz ? FIFTY_HALF : SIXTY_HALF) + {{LINE_W{1'b0}}, field};
        limit    = mode.interlaced ? full_lim : half_lim;
    end

endmodule

// File: rtl/vbeam_stepper.sv
module vbeam_stepper #(
    parameter int LINE_W = 11
) (
    input  logic [LINE_W-1:0] line_q,
    input  logic [LINE_W-1:0] trigger,
    input  logic [LINE_W:0]   limit,
    output logic [LINE_W-1:0] line_next,
    output logic              hit,
    output logic              wrap
);
    logic [LINE_W:0] inc;

    always_comb begin
        inc       = {1'b0, line_q} + 1'b1;
        hit       = (inc == {1'b0, trigger});
        wrap      = (inc >= limit);
        line_next = wrap ? LINE_W'(1) : inc[LINE_W-1:0];
    end

endmodule

// File: rtl/vbeam_hwreg.sv
module vbeam_hwreg
    import vbeam_pkg::*;
#(
    parameter int              WIDTH  = 24,
    parameter logic [ADDR_W-1:0] HI_OFS = 7'h1C
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (hits_reg(req, HI_OFS))
            q <= WIDTH'(merge_half(32'(q), req, HI_OFS));
    end

endmodule

// File: rtl/vbeam_ctl.sv
module vbeam_ctl
    import vbeam_pkg::*;
#(
    parameter int LINE_W     = 11,
    parameter int NTSC_LINES = 525,
    parameter int PAL_LINES  = 625,
    parameter int FB_W       = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_word,
    input  logic [6:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              fuse_bit,
    input  logic              line_step,
    output logic              irq
);
    localparam int LINE_MSB = POS_LSB + LINE_W - 1;

    bus_req_t     req;
    logic [15:1]  ctrl_q;
    logic         field_q;
    logic [31:0]  pos_q;
    logic [31:0]  int_q;
    timing_mode_t mode;
    logic [LINE_W:0]   line_limit;
    logic [LINE_W-1:0] line_next;
    logic         step_hit;
    logic         step_wrap;
    logic         ctrl_wr;
    logic         pos_wr;
    logic         int_wr;
    logic [FB_COUNT-1:0][FB_W-1:0] fb_q;
    logic [FB_COUNT-1:0][31:0]     fb32;
    logic [31:0]  int_next;

    assign req     = '{we: bus_we, word: bus_word, addr: bus_addr, wdata: bus_wdata};
    assign ctrl_wr = bus_we && ((bus_word && bus_addr == OFS_CTRL_W) ||
                                (!bus_word && bus_addr == OFS_CTRL_H));
    assign pos_wr  = hits_reg(req, OFS_POS_HI);
    assign int_wr  = hits_reg(req, OFS_IRQ_HI);
    assign mode    = decode_mode({ctrl_q, 1'b0});

    vbeam_limit #(
        .LINE_W     (LINE_W),
        .NTSC_LINES (NTSC_LINES),
        .PAL_LINES  (PAL_LINES)
    ) u_limit (
        .mode  (mode),
        .field (field_q),
        .limit (line_limit)
    );

    vbeam_stepper #(.LINE_W(LINE_W)) u_step (
        .line_q    (pos_q[LINE_MSB:POS_LSB]),
        .trigger   (int_q[LINE_MSB:POS_LSB]),
        .limit     (line_limit),
        .line_next (line_next),
        .hit       (step_hit),
        .wrap      (step_wrap)
    );

    generate
        for (genvar g = 0; g < FB_COUNT; g++) begin : g_fb
            vbeam_hwreg #(
                .WIDTH  (FB_W),
                .HI_OFS (fb_hi_ofs(g))
            ) u_fb (
                .clk (clk),
                .rst (rst),
                .req (req),
                .q   (fb_q[g])
            );
            assign fb32[g] = 32'(fb_q[g]);
        end
    endgenerate

    // display control and field tracking
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            field_q <= 1'b0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= bus_wdata[15:1];
            if (ctrl_wr)
                field_q <= 1'b0;
            else if (line_step && step_wrap)
                field_q <= ~field_q;
        end
    end

    // beam position: a bus write wins over a step in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (pos_wr)
            pos_q <= merge_half(pos_q, req, OFS_POS_HI);
        else if (line_step)
            pos_q[LINE_MSB:POS_LSB] <= line_next;
    end

    // interrupt word: a match ORs the flag into whatever is written
    always_comb begin
        int_next = int_wr ? merge_half(int_q, req, OFS_IRQ_HI) : int_q;
        if (line_step && step_hit)
            int_next[FLAG_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            int_q <= '0;
        else
            int_q <= int_next;
    end

    assign irq = int_q[FLAG_BIT] & int_q[ENA_BIT];

    always_comb begin
        bus_rdata = '0;
        if (bus_word) begin
            case (bus_addr)
                OFS_CTRL_W: bus_rdata = {16'h0, ctrl_q, fuse_bit};
                OFS_FBT_HI: bus_rdata = fb32[0];
                OFS_FBB_HI: bus_rdata = fb32[1];
                OFS_POS_HI: bus_rdata = pos_q;
                OFS_IRQ_HI: bus_rdata = int_q;
                default:    bus_rdata = '0;
            endcase
        end else begin
            case (bus_addr)
                OFS_CTRL_H: bus_rdata = {16'h0, ctrl_q, fuse_bit};
                OFS_FBT_HI: bus_rdata = {16'h0, fb32[0][31:16]};
                OFS_FBT_LO: bus_rdata = {16'h0, fb32[0][15:0]};
                OFS_FBB_HI: bus_rdata = {16'h0, fb32[1][31:16]};
                OFS_FBB_LO: bus_rdata = {16'h0, fb32[1][15:0]};
                OFS_POS_HI: bus_rdata = {16'h0, pos_q[31:16]};
                OFS_POS_LO: bus_rdata = {16'h0, pos_q[15:0]};
                OFS_IRQ_HI: bus_rdata = {16'h0, int_q[31:16]};
                OFS_IRQ_LO: bus_rdata = {16'h0, int_q[15:0]};
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/vbeam_chk.sv
module vbeam_chk #(
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic              bus_word,
    input logic [6:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              line_step,
    input logic              irq,
    input logic [31:0]       pos_q,
    input logic [31:0]       int_q,
    input logic [LINE_W:0]   limit
);
    logic pos_touch;
    logic int_hi_touch;
    logic clr_bit;

    assign pos_touch    = bus_we && ((bus_word && bus_addr == 7'h2C) ||
                          (!bus_word && (bus_addr == 7'h2C || bus_addr == 7'h2E)));
    assign int_hi_touch = bus_we && bus_addr == 7'h30;
    assign clr_bit      = bus_word ? bus_wdata[31] : bus_wdata[15];

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!line_step && !pos_touch) |=> $stable(pos_q));

    a_r4_wrap_range: assert property (@(posedge clk) disable iff (rst)
        (line_step && !pos_touch) |=>
        (pos_q[16 +: LINE_W] != '0 && {1'b0, pos_q[16 +: LINE_W]} < $past(limit)));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (int_q[31] && !int_hi_touch) |=> int_q[31]);

    a_r7_clear_drops_irq: assert property (@(posedge clk) disable iff (rst)
        (int_hi_touch && !clr_bit && !line_step) |=> !irq);

    a_r9_fb_mask: assert property (@(posedge clk) disable iff (rst)
        (bus_word && (bus_addr == 7'h1C || bus_addr == 7'h24)) |-> bus_rdata[31:24] == 8'h0);

endmodule

bind vbeam_ctl vbeam_chk #(.LINE_W(LINE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_word  (bus_word),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .line_step (line_step),
    .irq       (irq),
    .pos_q     (pos_q),
    .int_q     (int_q),
    .limit     (line_limit)
);

// File: tb/sim_vbeam_ctl.sv
`timescale 1ns/1ps
module sim_vbeam_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic        bus_word = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fuse_bit = 1'b1;
    logic        line_step = 1'b0;
    logic        irq;

    int nchk = 0;
    int nerr = 0;

    logic [31:0] m_pos;
    logic [31:0] m_int;
    logic [15:0] m_ctrl;
    logic        m_field;

    always #2.5 clk = ~clk;

    vbeam_ctl #(.NTSC_LINES(11), .PAL_LINES(15)) u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fuse_bit(fuse_bit), .line_step(line_step), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit w, input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_word = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input bit w, input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_word = w; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_step();
        @(negedge clk);
        line_step = 1'b1;
        @(negedge clk);
        line_step = 1'b0;
    endtask

    function automatic int m_lim(logic [15:0] c, logic f);
        int full;
        full = (c[9:8] == 2'd1) ? 15 : 11;
        return c[2] ? (full / 2 + int'(f)) : full;
    endfunction

    task automatic m_step();
        int n;
        n = int'(m_pos[26:16]) + 1;
        if (n == int'(m_int[26:16])) m_int[31] = 1'b1;
        if (n >= m_lim(m_ctrl, m_field)) begin
            n = 1;
            m_field = ~m_field;
        end
        m_pos[26:16] = 11'(n);
    endtask

    task automatic step_and_check(input string tag);
        logic [31:0] d;
        m_step();
        pulse_step();
        rd(1'b1, 7'h2C, d);
        chk({tag, " R4 beam word"}, d, m_pos);
        rd(1'b1, 7'h30, d);
        chk({tag, " R6 irq word"}, d, m_int);
        chk({tag, " R6 irq pin"}, 32'(irq), 32'(m_int[31] & m_int[28]));
    endtask

    initial begin
        #(5.0 * 150000);
        nerr++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R10 fuse
        rd(1'b1, 7'h00, d); chk("R1 ctrl reset", d, 32'h1);
        rd(1'b1, 7'h1C, d); chk("R1 fb top reset", d, 32'h0);
        rd(1'b1, 7'h24, d); chk("R1 fb bottom reset", d, 32'h0);
        rd(1'b1, 7'h2C, d); chk("R1 beam reset", d, 32'h0);
        rd(1'b1, 7'h30, d); chk("R1 irq word reset", d, 32'h0);
        chk("R1 irq pin reset", 32'(irq), 32'h0);

        wr(1'b1, 7'h00, 32'hFFFF_FFFF);
        fuse_bit = 1'b0;
        rd(1'b1, 7'h00, d); chk("R10 ctrl word fuse0", d, 32'h0000_FFFE);
        rd(1'b0, 7'h02, d); chk("R10 ctrl half fuse0", d, 32'h0000_FFFE);
        fuse_bit = 1'b1;
        rd(1'b0, 7'h02, d); chk("R10 ctrl half fuse1", d, 32'h0000_FFFF);

        // R8 / R9 framebuffer merging and masking
        wr(1'b1, 7'h1C, 32'hDEAD_BEEF);
        rd(1'b1, 7'h1C, d); chk("R9 fb top word", d, 32'h00AD_BEEF);
        wr(1'b0, 7'h1C, 32'h0000_1234);
        rd(1'b1, 7'h1C, d); chk("R8 fb top hi merge", d, 32'h0034_BEEF);
        wr(1'b0, 7'h1E, 32'h0000_5678);
        rd(1'b1, 7'h1C, d); chk("R8 fb top lo merge", d, 32'h0034_5678);
        rd(1'b0, 7'h1C, d); chk("R8 fb top hi read", d, 32'h0000_0034);
        wr(1'b0, 7'h26, 32'h0000_A5A5);
        wr(1'b0, 7'h24, 32'h0000_FF01);
        rd(1'b1, 7'h24, d); chk("R9 fb bottom halves", d, 32'h0001_A5A5);
        rd(1'b0, 7'h26, d); chk("R8 fb bottom lo read", d, 32'h0000_A5A5);

        // R12 unmapped offsets
        wr(1'b1, 7'h04, 32'hFFFF_FFFF);
        wr(1'b0, 7'h00, 32'h0000_0000);
        wr(1'b1, 7'h1E, 32'h0000_0000);
        rd(1'b1, 7'h04, d); chk("R12 unmapped word read", d, 32'h0);
        rd(1'b0, 7'h00, d); chk("R12 unmapped half read", d, 32'h0);
        rd(1'b1, 7'h00, d); chk("R12 ctrl untouched", d, 32'h0000_FFFF);
        rd(1'b1, 7'h1C, d); chk("R12 fb top untouched", d, 32'h0034_5678);

        // R2 R3 R4 R6 R7 R11 mode and trigger sweep
        for (int fmt = 0; fmt < 4; fmt++) begin
            for (int nin = 0; nin < 2; nin++) begin
                for (int t = 0; t < 17; t++) begin
                    m_ctrl  = 16'((fmt << 8) | (nin << 2));
                    m_field = 1'b0;
                    wr(1'b0, 7'h02, 32'(m_ctrl));
                    m_pos = 32'h8000_1234;
                    wr(1'b1, 7'h2C, m_pos);
                    m_int = (32'(t & 1) << 28) | (32'(t) << 16) | 32'h0000_00C3;
                    wr(1'b1, 7'h30, m_int);
                    for (int s = 0; s < 2 * m_lim(m_ctrl, 1'b0) + 9; s++) begin
                        step_and_check($sformatf("R3 fmt%0d nin%0d t%0d s%0d", fmt, nin, t, s));
                        if (m_int[31]) begin
                            m_int[31] = 1'b0;
                            wr(1'b0, 7'h30, 32'(m_int[31:16]));
                            chk("R7 hi clear irq", 32'(irq), 32'h0);
                            rd(1'b1, 7'h30, d);
                            chk("R7 hi clear word", d, m_int);
                        end
                    end
                end
            end
        end

        // R11 control write resets field, keeps counter
        m_ctrl = 16'h0004; m_field = 1'b0;
        wr(1'b0, 7'h02, 32'(m_ctrl));
        m_pos = 32'h0000_0000; wr(1'b1, 7'h2C, m_pos);
        m_int = 32'h0; wr(1'b1, 7'h30, m_int);
        for (int s = 0; s < 7; s++) step_and_check("R11 pre");
        wr(1'b0, 7'h02, 32'(m_ctrl));
        m_field = 1'b0;
        rd(1'b1, 7'h2C, d); chk("R11 counter kept", d, m_pos);
        for (int s = 0; s < 6; s++) step_and_check("R11 post");

        // R13 out of range counter and trigger at limit
        m_ctrl = 16'h0000; m_field = 1'b0;
        wr(1'b0, 7'h02, 32'(m_ctrl));
        m_pos = 32'(2000) << 16; wr(1'b1, 7'h2C, m_pos);
        step_and_check("R13 from 2000");
        chk("R13 line after 2000", 32'(m_pos[26:16]), 32'd1);
        m_pos = 32'(2047) << 16; wr(1'b1, 7'h2C, m_pos);
        step_and_check("R13 from 2047");
        m_pos = 32'(10) << 16; wr(1'b1, 7'h2C, m_pos);
        m_int = 32'h1000_0000 | (32'd11 << 16); wr(1'b1, 7'h30, m_int);
        step_and_check("R13 trigger at limit");
        chk("R13 irq at limit", 32'(irq), 32'h1);

        // R7 low half write keeps the flag
        wr(1'b0, 7'h32, 32'h0000_0055);
        m_int[15:0] = 16'h0055;
        rd(1'b1, 7'h30, d); chk("R7 lo write keeps flag", d, m_int);
        chk("R7 irq after lo write", 32'(irq), 32'h1);
        // R7 whole word clear
        m_int = 32'h1000_0000; wr(1'b1, 7'h30, m_int);
        chk("R7 word clear irq", 32'(irq), 32'h0);

        // R5 idle: no step, no change
        repeat (20) @(negedge clk);
        rd(1'b1, 7'h2C, d); chk("R5 idle beam", d, m_pos);
        // R8 beam halfword merge
        wr(1'b0, 7'h2E, 32'h0000_BEEF);
        m_pos[15:0] = 16'hBEEF;
        rd(1'b1, 7'h2C, d); chk("R8 beam lo merge", d, m_pos);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule